// File: doc/BRIEF.md
# SPI Pin Serializer/Deserializer

This block cuts pin count by carrying the state of a group of parallel signals over a four-wire SPI link. Each serialization frame shifts out one word and, at the same time, shifts in a word from the far end. The outgoing word comes from one of two sources, picked by `src_sel`: a word held by software (`sw_data`) or the live parallel inputs (`par_in`). The incoming word is presented on the parallel outputs (`par_out`). It is also copied into a receive register (`rx_data`), which the host reads.

Two modes decide when a frame starts. In continuous mode, frames repeat with a programmable idle gap between them. In change mode, a frame starts only when the selected source differs from the last word that was serialized. A command frame can also be requested through `cmd_req`, for control or diagnostic traffic to the far end. A command request wins at the next frame boundary. It never cuts into a frame that is already running.

Top module: `pin_serdes_spi`

## Requirements
- R1: Out of reset, `cs_n` is 1, `sclk` and `mosi` are 0, `par_out` and `rx_data` are zero, and `rx_valid` and `cmd_ack` are 0. While `cs_n` is 1, `sclk` and `mosi` stay 0.
- R2: A serialization frame sends `sw_data` when `src_sel` is 0 and `par_in` when `src_sel` is 1. The source that is not selected has no effect on the frames or on when they start.
- R3: In change mode (`mode_change` = 1), a serialization frame starts only when the selected source differs from the last serialized word. That last word is zero after reset. While the source equals the last word, no frame starts.
- R4: In continuous mode (`mode_change` = 0), frames repeat back to back. Between the end of one frame and the start of the next, `cs_n` stays high for exactly `gap_len`+1 clock cycles.
- R5: A frame drops `cs_n` for W bits, sent MSB first. Each bit takes two clock cycles: one with `sclk` 0, then one with `sclk` 1. `mosi` holds steady while `sclk` is 1. `miso` is sampled on the rising edge of `sclk`.
- R6: `par_out` changes only on the clock edge that ends a serialization frame. It then takes the full W-bit word received in that frame. Command frames leave it unchanged.
- R7: On the edge that ends any frame, `rx_data` takes the received word and `rx_cmd` marks a command frame with 1. `rx_valid` goes high for exactly one cycle.
- R8: When a frame may start and `cmd_req` is 1, a command frame that sends `cmd_data` starts in preference to a serialization frame. `cmd_ack` is 1 for the one cycle in which the request is accepted. A running frame is never cut short. A command frame does not change the last-serialized word used by R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 1 | Source select: 0 = `sw_data`, 1 = `par_in` |
| mode_change | input | 1 | 1 = start on change, 0 = continuous |
| gap_len | input | GAPW | Gap length in cycles; `cs_n` stays high for `gap_len`+1 cycles between frames |
| sw_data | input | W | Word written by software |
| par_in | input | W | Parallel input pins |
| cmd_req | input | 1 | Request for a command frame, held until acknowledged |
| cmd_data | input | W | Word sent in a command frame |
| cmd_ack | output | 1 | Command request accepted (one cycle) |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| par_out | output | W | Parallel outputs, updated once per serialization frame |
| rx_data | output | W | Word received in the last frame |
| rx_cmd | output | 1 | Last received frame was a command frame |
| rx_valid | output | 1 | One-cycle pulse when a frame ends |

## Verification
A frame starts on the clock edge that ends the single idle cycle in which its trigger is seen, so `cs_n` is low at the next falling clock edge. Results arrive one edge after the last `sclk`-high cycle: `par_out`, `rx_data`, `rx_cmd` and the `rx_valid` pulse change on the same edge that raises `cs_n`. The bench changes inputs 1 ns after a rising edge. It compares everything at the falling edge against a model that keeps a snapshot of the previous falling edge's inputs. This matches what the design saw at the rising edge in between. The model predicts, cycle by cycle, whether `cs_n` drops next, and it judges each frame's content, `cmd_ack` and the results at the first falling edge at which they are due.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // Sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_GAP  = 2'd2
  } seq_state_e;

  // Kind of the frame in flight
  typedef enum logic {
    KIND_PIN = 1'b0,
    KIND_CMD = 1'b1
  } frame_kind_e;

endpackage

// File: rtl/pss_trigger.sv
module pss_trigger #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_sel,
  input  logic         mode_change,
  input  logic [W-1:0] sw_data,
  input  logic [W-1:0] par_in,
  input  logic         ser_start,
  output logic [W-1:0] src_word,
  output logic         want_frame
);

  logic [W-1:0] last_q;

  function automatic logic differs(input logic [W-1:0] a, input logic [W-1:0] b);
    return |(a ^ b);
  endfunction

  assign src_word   = src_sel ? par_in : sw_data;
  assign want_frame = !mode_change || differs(src_word, last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (ser_start) begin
      last_q <= src_word;
    end
  end

endmodule

// File: rtl/pss_shifter.sv
module pss_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load_word,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         busy,
  output logic         last_edge,
  output logic [W-1:0] rx_word
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  tx_q;
  logic          ph_q;
  logic [CW-1:0] idx_q;

  function automatic logic is_final(input logic [CW-1:0] i);
    return i == CW'(W - 1);
  endfunction

  assign last_edge = busy & ph_q & is_final(idx_q);
  assign mosi      = busy & tx_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      ph_q    <= 1'b0;
      idx_q   <= '0;
      tx_q    <= '0;
      rx_word <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      tx_q  <= load_word;
      ph_q  <= 1'b0;
      idx_q <= '0;
      sclk  <= 1'b0;
    end else if (busy) begin
      if (!ph_q) begin
        ph_q    <= 1'b1;
        sclk    <= 1'b1;
        rx_word <= {rx_word[W-2:0], miso};
      end else begin
        ph_q <= 1'b0;
        sclk <= 1'b0;
        if (is_final(idx_q)) begin
          busy <= 1'b0;
        end else begin
          tx_q  <= {tx_q[W-2:0], 1'b0};
          idx_q <= idx_q + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pss_sequencer.sv
module pss_sequencer
  import pss_pkg::*;
#(
  parameter int GAPW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_req,
  input  logic            want_frame,
  input  logic            last_edge,
  input  logic [GAPW-1:0] gap_len,
  output logic            start,
  output logic            start_cmd,
  output logic            cur_cmd,
  output logic            frame_end
);

  seq_state_e      st_q;
  frame_kind_e     kind_q;
  logic [GAPW-1:0] gcnt_q;

  function automatic logic gap_over(input logic [GAPW-1:0] cnt, input logic [GAPW-1:0] len);
    return ({1'b0, cnt} + {{GAPW{1'b0}}, 1'b1}) >= {1'b0, len};
  endfunction

  assign start     = (st_q == SQ_IDLE) && (cmd_req || want_frame);
  assign start_cmd = (st_q == SQ_IDLE) && cmd_req;
  assign frame_end = (st_q == SQ_RUN) && last_edge;
  assign cur_cmd   = (kind_q == KIND_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      kind_q <= KIND_PIN;
      gcnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (start) begin
            st_q   <= SQ_RUN;
            kind_q <= cmd_req ? KIND_CMD : KIND_PIN;
          end
        end
        SQ_RUN: begin
          if (last_edge) begin
            if (gap_len == '0) begin
              st_q <= SQ_IDLE;
            end else begin
              st_q   <= SQ_GAP;
              gcnt_q <= '0;
            end
          end
        end
        SQ_GAP: begin
          if (gap_over(gcnt_q, gap_len)) begin
            st_q <= SQ_IDLE;
          end else begin
            gcnt_q <= gcnt_q + GAPW'(1);
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pin_serdes_spi.sv
module pin_serdes_spi #(
  parameter int W    = 16,
  parameter int GAPW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_sel,
  input  logic            mode_change,
  input  logic [GAPW-1:0] gap_len,
  input  logic [W-1:0]    sw_data,
  input  logic [W-1:0]    par_in,
  input  logic            cmd_req,
  input  logic [W-1:0]    cmd_data,
  output logic            cmd_ack,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic            cs_n,
  output logic [W-1:0]    par_out,
  output logic [W-1:0]    rx_data,
  output logic            rx_cmd,
  output logic            rx_valid
);

  logic [W-1:0] src_word;
  logic [W-1:0] load_word;
  logic [W-1:0] rx_word;
  logic         want_frame;
  logic         start;
  logic         start_cmd;
  logic         ser_start;
  logic         cur_cmd;
  logic         frame_end;
  logic         busy;
  logic         last_edge;

  assign ser_start = start && !start_cmd;
  assign load_word = start_cmd ? cmd_data : src_word;
  assign cmd_ack   = start_cmd;
  assign cs_n      = !busy;

  pss_trigger #(.W(W)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .mode_change(mode_change),
    .sw_data    (sw_data),
    .par_in     (par_in),
    .ser_start  (ser_start),
    .src_word   (src_word),
    .want_frame (want_frame)
  );

  pss_sequencer #(.GAPW(GAPW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_req   (cmd_req),
    .want_frame(want_frame),
    .last_edge (last_edge),
    .gap_len   (gap_len),
    .start     (start),
    .start_cmd (start_cmd),
    .cur_cmd   (cur_cmd),
    .frame_end (frame_end)
  );

  pss_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load_word(load_word),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .busy     (busy),
    .last_edge(last_edge),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out  <= '0;
      rx_data  <= '0;
      rx_cmd   <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= frame_end;
      if (frame_end) begin
        rx_data <= rx_word;
        rx_cmd  <= cur_cmd;
        if (!cur_cmd) begin
          par_out <= rx_word;
        end
      end
    end
  end

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         sclk,
  input logic         mosi,
  input logic [W-1:0] par_out,
  input logic         rx_valid,
  input logic         cmd_ack,
  input logic         cmd_req,
  input logic         frame_end
);

  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && !mosi));

  a_r5_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk) |-> $stable(mosi));

  a_r6_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(par_out));

  a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> rx_valid);

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> !rx_valid);

  a_r8_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> (cs_n && cmd_req));

  a_r8_ack_starts: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> !cs_n);

  a_r8_no_break: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !frame_end) |=> !cs_n);

endmodule

bind pin_serdes_spi pss_checker #(.W(W)) u_pss_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .par_out  (par_out),
  .rx_valid (rx_valid),
  .cmd_ack  (cmd_ack),
  .cmd_req  (cmd_req),
  .frame_end(frame_end)
);

// File: tb/test_pin_serdes_spi.sv
module test_pin_serdes_spi;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W    = 16;
  localparam int GAPW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            src_sel = 1'b0;
  logic            mode_change = 1'b1;
  logic [GAPW-1:0] gap_len = 8'd2;
  logic [W-1:0]    sw_data = '0;
  logic [W-1:0]    par_in = '0;
  logic            cmd_req = 1'b0;
  logic [W-1:0]    cmd_data = '0;
  logic            miso = 1'b0;
  logic            cmd_ack, sclk, mosi, cs_n, rx_cmd, rx_valid;
  logic [W-1:0]    par_out, rx_data;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_serdes_spi #(.W(W), .GAPW(GAPW)) i_pin_serdes_spi (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .mode_change(mode_change),
    .gap_len(gap_len), .sw_data(sw_data), .par_in(par_in), .cmd_req(cmd_req),
    .cmd_data(cmd_data), .cmd_ack(cmd_ack), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .par_out(par_out), .rx_data(rx_data),
    .rx_cmd(rx_cmd), .rx_valid(rx_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Reference model and far-end slave, evaluated at every falling edge
  bit          prev_cs = 1;
  bit          exp_low = 0;
  int          hi_cnt = 1000;
  logic [W-1:0] snap_src = '0, snap_cdata = '0;
  bit          snap_cmd = 0, snap_mode = 1;
  bit          kind_cmd = 0;
  logic [W-1:0] exp_word = '0, cap = '0, sword = 16'hACE1;
  logic [W-1:0] m_last = '0, m_par = '0;
  int          k = 0;
  int          pin_frames = 0, cmd_frames = 0;

  always @(negedge clk) begin
    if (rst_n && started) begin
      automatic bit cs = cs_n;
      automatic string tag;
      tag = snap_cmd ? "R8" : (snap_mode ? "R3" : "R4");
      if (prev_cs) chk(tag, cs, !exp_low);
      if (prev_cs && !cs) begin
        kind_cmd = snap_cmd;
        exp_word = snap_cmd ? snap_cdata : snap_src;
        if (snap_cmd) cmd_frames++;
        else begin
          pin_frames++;
          m_last = snap_src;
        end
        sword = {sword[W-2:0], sword[W-1]} ^ 16'h1D35;
        cap = '0;
        k = 0;
      end
      if (!prev_cs && cs) begin
        chk(kind_cmd ? "R8" : "R2", cap, exp_word);
        chk("R5", k, W);
        chk("R7", rx_valid, 1);
        chk("R7", rx_data, sword);
        chk("R7", rx_cmd, kind_cmd);
        if (!kind_cmd) m_par = sword;
      end else begin
        chk("R7", rx_valid, 0);
      end
      chk("R6", par_out, m_par);
      if (cs) begin
        chk("R1", {sclk, mosi}, 2'b00);
      end else if (sclk) begin
        cap = {cap[W-2:0], mosi};
        k++;
      end else if (k < W) begin
        miso = sword[W-1-k];
      end
      if (cs) hi_cnt++;
      else hi_cnt = 0;
      snap_src   = src_sel ? par_in : sw_data;
      snap_cmd   = cmd_req;
      snap_cdata = cmd_data;
      snap_mode  = mode_change;
      exp_low = cs && (hi_cnt >= int'(gap_len) + 1) &&
                (cmd_req || !mode_change || (snap_src != m_last));
      chk("R8", cmd_ack, exp_low && cmd_req);
      prev_cs = cs;
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    step(2);
    // R1 reset state while reset is held
    chk("R1", {cs_n, sclk, mosi, rx_valid, cmd_ack}, 5'b10000);
    chk("R1", par_out, 0);
    chk("R1", rx_data, 0);
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R1", {cs_n, sclk, mosi}, 3'b100);
    started = 1;

    // R3: source equals reset value, so no frame
    step(40);
    chk("R3", pin_frames, 0);
    sw_data = 16'hA5C3;
    step(80);
    chk("R3", pin_frames, 1);
    step(40);
    chk("R3", pin_frames, 1);

    // R2: pin source selected, software word ignored
    src_sel = 1'b1;
    par_in  = 16'h3C0F;
    step(80);
    chk("R2", pin_frames, 2);
    sw_data = 16'h1111;
    step(60);
    chk("R2", pin_frames, 2);
    par_in = 16'h8001;
    step(60);
    chk("R2", pin_frames, 3);

    // R4: continuous mode with a gap of 3
    gap_len = 8'd3;
    mode_change = 1'b0;
    step(300);
    chk("R4", pin_frames > 8, 1);

    // R8: command interleaved into the continuous stream
    cmd_data = 16'hC0DE;
    cmd_req  = 1'b1;
    while (cmd_frames < 1) step(1);
    cmd_req = 1'b0;
    step(120);

    // stop, then continuous with no gap
    mode_change = 1'b1;
    step(100);
    gap_len = 8'd0;
    mode_change = 1'b0;
    step(200);
    mode_change = 1'b1;
    step(80);

    // R8: command while idle in change mode, par_out kept
    cmd_data = 16'h0F0F;
    cmd_req  = 1'b1;
    while (cmd_frames < 2) step(1);
    cmd_req = 1'b0;
    begin
      automatic int pf = pin_frames;
      step(100);
      chk("R8", pin_frames, pf);
    end
    chk("R8", cmd_frames, 2);
    chk("R6", par_out, m_par);
    finish_run();
  end

endmodule